// File: doc/BRIEF.md
# PECI Temperature Poll Sequencer

This block runs periodic temperature polls over an abstract PECI transaction engine and decides, for every poll, whether the returned reading reaches the temperature register. While monitoring is on, a poll starts once every `POLL_INTERVAL` cycles. Each poll can begin with a package-state query, then issues the temperature read. The completion code of the query is then checked against a small set of policy bits. The outcome is one of three: load the measured value, load zero, or leave the register unchanged.

The engine is reached through a one-cycle request that carries a command code. The engine answers with a one-cycle acknowledge, and the completion code and data travel together with it. The block also launches a single manual command when software strobes a start input while a pending flag is high.

Top module: `peci_poll_seq`

## Requirements
- R1: The policy register loads `cfg_wdata` on a cycle with `cfg_wr` high and resets to all zeros. Its bit map is: [0] query enable, [1] special-code update gate, [2] special-code value enable, [3] special-code zero enable, [4] normal-code value enable, [5] normal-code zero enable.
- R2: While reset is high, `temp_q` is 0 and both `temp_commit` and `eng_req` are 0.
- R3: A poll starts only while `mon_en` is high. Temperature-read requests of back-to-back polls are exactly `POLL_INTERVAL` cycles apart. With `mon_en` low, no poll request appears.
- R4: With the query enable set, every temperature read (command 2) is preceded by a state query (command 1) in the same poll. With it clear, no query is issued.
- R5: `eng_req` is high for a single cycle, and no new request is made until the previous one has been acknowledged.
- R6: When the deciding code is 0x82 and the update gate is clear, the register is left unchanged.
- R7: When the deciding code is 0x82 and the gate is set, zero is loaded if the special zero enable is set. Otherwise the read value is loaded if the special value enable is set. Otherwise the register holds.
- R8: When the deciding code has bit 7 clear, zero is loaded if the normal zero enable is set. Otherwise the read value is loaded if the normal value enable is set. Otherwise the register holds.
- R9: Any other code (bit 7 set and not 0x82) leaves the register unchanged.
- R10: The deciding code is the query's completion code when a query was issued in that poll, and the temperature read's own code otherwise.
- R11: `temp_commit` is a single-cycle strobe in the cycle after the temperature read's acknowledge. `temp_q` changes only on the edge that ends a strobe cycle.
- R12: A manual start (`man_start` with `man_pending` high) issues command 3 only when the sequencer is idle. It is ignored while a poll is in progress or when `man_pending` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Temperature monitoring enable |
| cfg_wr | input | 1 | Policy register write strobe |
| cfg_wdata | input | 6 | Policy register write data |
| man_start | input | 1 | Manual command start strobe |
| man_pending | input | 1 | Manual command pending flag |
| eng_req | output | 1 | Transaction request pulse |
| eng_cmd | output | 2 | Command code: 1 query, 2 temperature read, 3 manual |
| eng_ack | input | 1 | Transaction acknowledge pulse |
| eng_cc | input | 8 | Completion code, valid with acknowledge |
| eng_data | input | TEMP_W | Read data, valid with acknowledge |
| temp_q | output | TEMP_W | Temperature register |
| temp_commit | output | 1 | Register update strobe |

## Verification
A wrong policy decision or a stale deciding code shows up on `temp_q` two cycles after the temperature acknowledge, as a wrong value or a missing or extra `temp_commit` strobe in the cycle just before. A sequencer that skips or reorders the query shows up on `eng_cmd` at the very next request. A broken interval timer shifts the spacing between temperature-read requests within one poll period. A manual start taken at the wrong time shows up as a command 3 request on the following cycle.

// File: rtl/peci_poll_pkg.sv
package peci_poll_pkg;

    localparam int CC_W     = 8;
    localparam int CC_ERR   = 7;
    localparam logic [CC_W-1:0] CC_SPECIAL = 8'h82;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_QUERY  = 2'd1,
        CMD_TEMP   = 2'd2,
        CMD_MANUAL = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_QUERY,
        S_WAIT_QUERY,
        S_GETTEMP,
        S_WAIT_TEMP,
        S_COMMIT,
        S_MANUAL,
        S_WAIT_MAN
    } state_e;

    typedef enum logic [1:0] {
        ACT_KEEP,
        ACT_VALUE,
        ACT_ZERO
    } act_e;

    // Packed: last field is bit 0.
    typedef struct packed {
        logic nm_zero;
        logic nm_pos;
        logic sp_zero;
        logic sp_pos;
        logic sp_gate;
        logic query_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic act_e decide(input cfg_t c, input logic [CC_W-1:0] code);
        act_e a;
        a = ACT_KEEP;
        if (code == CC_SPECIAL) begin
            if (c.sp_gate) begin
                if (c.sp_zero)     a = ACT_ZERO;
                else if (c.sp_pos) a = ACT_VALUE;
            end
        end else if (!code[CC_ERR]) begin
            if (c.nm_zero)     a = ACT_ZERO;
            else if (c.nm_pos) a = ACT_VALUE;
        end
        return a;
    endfunction

endpackage

// File: rtl/peci_poll_cfg.sv
module peci_poll_cfg
    import peci_poll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (wr) cfg <= cfg_t'(wdata);
    end
endmodule

// File: rtl/peci_poll_timer.sv
module peci_poll_timer #(
    parameter int INTERVAL = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic consume,
    output logic due
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST)  due <= 1'b1;
            else if (consume) due <= 1'b0;
        end
    end
endmodule

// File: rtl/peci_poll_fsm.sv
module peci_poll_fsm
    import peci_poll_pkg::*;
#(
    parameter int TEMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_due,
    input  logic              mon_en,
    input  logic              query_en,
    input  logic              man_go,
    input  logic              eng_ack,
    input  logic [CC_W-1:0]   eng_cc,
    input  logic [TEMP_W-1:0] eng_data,
    output state_e            state,
    output logic              consume,
    output logic              eng_req,
    output cmd_e              eng_cmd,
    output logic [CC_W-1:0]   code,
    output logic [TEMP_W-1:0] sample,
    output logic              in_commit
);
    state_e nxt;
    logic   start_poll;
    logic   did_query;

    assign start_poll = mon_en && poll_due && !man_go;
    assign consume    = (state == S_IDLE) && start_poll;
    assign in_commit  = (state == S_COMMIT);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (man_go)          nxt = S_MANUAL;
                else if (start_poll) nxt = query_en ? S_QUERY : S_GETTEMP;
            end
            S_QUERY:      nxt = S_WAIT_QUERY;
            S_WAIT_QUERY: if (eng_ack) nxt = S_GETTEMP;
            S_GETTEMP:    nxt = S_WAIT_TEMP;
            S_WAIT_TEMP:  if (eng_ack) nxt = S_COMMIT;
            S_COMMIT:     nxt = S_IDLE;
            S_MANUAL:     nxt = S_WAIT_MAN;
            S_WAIT_MAN:   if (eng_ack) nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_comb begin
        eng_req = 1'b0;
        eng_cmd = CMD_NONE;
        unique case (state)
            S_QUERY:   begin eng_req = 1'b1; eng_cmd = CMD_QUERY;  end
            S_GETTEMP: begin eng_req = 1'b1; eng_cmd = CMD_TEMP;   end
            S_MANUAL:  begin eng_req = 1'b1; eng_cmd = CMD_MANUAL; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            did_query <= 1'b0;
            code      <= '0;
            sample    <= '0;
        end else begin
            state <= nxt;
            if (consume) did_query <= query_en;
            if (state == S_WAIT_QUERY && eng_ack) code <= eng_cc;
            if (state == S_WAIT_TEMP && eng_ack) begin
                sample <= eng_data;
                if (!did_query) code <= eng_cc;
            end
        end
    end
endmodule

// File: rtl/peci_poll_commit.sv
module peci_poll_commit
    import peci_poll_pkg::*;
#(
    parameter int TEMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_commit,
    input  cfg_t              cfg,
    input  logic [CC_W-1:0]   code,
    input  logic [TEMP_W-1:0] sample,
    output logic [TEMP_W-1:0] temp_q,
    output logic              temp_commit
);
    act_e act;

    assign act         = decide(cfg, code);
    assign temp_commit = in_commit && (act != ACT_KEEP);

    always_ff @(posedge clk) begin
        if (rst)              temp_q <= '0;
        else if (temp_commit) temp_q <= (act == ACT_ZERO) ? '0 : sample;
    end
endmodule

// File: rtl/peci_poll_seq.sv
module peci_poll_seq
    import peci_poll_pkg::*;
#(
    parameter int TEMP_W        = 16,
    parameter int POLL_INTERVAL = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_en,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_wdata,
    input  logic              man_start,
    input  logic              man_pending,
    output logic              eng_req,
    output logic [1:0]        eng_cmd,
    input  logic              eng_ack,
    input  logic [7:0]        eng_cc,
    input  logic [TEMP_W-1:0] eng_data,
    output logic [TEMP_W-1:0] temp_q,
    output logic              temp_commit
);
    cfg_t              cfg;
    logic [CFG_W-1:0]  cfg_bits;
    state_e            state_w;
    logic [2:0]        state_bits;
    logic              poll_due;
    logic              consume;
    logic              man_go;
    cmd_e              cmd_w;
    logic [CC_W-1:0]   code_w;
    logic [TEMP_W-1:0] sample_w;
    logic              in_commit;

    assign man_go     = man_start && man_pending;
    assign eng_cmd    = cmd_w;
    assign cfg_bits   = cfg;
    assign state_bits = state_w;

    peci_poll_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    peci_poll_timer #(.INTERVAL(POLL_INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (mon_en),
        .consume (consume),
        .due     (poll_due)
    );

    peci_poll_fsm #(.TEMP_W(TEMP_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .poll_due  (poll_due),
        .mon_en    (mon_en),
        .query_en  (cfg.query_en),
        .man_go    (man_go),
        .eng_ack   (eng_ack),
        .eng_cc    (eng_cc),
        .eng_data  (eng_data),
        .state     (state_w),
        .consume   (consume),
        .eng_req   (eng_req),
        .eng_cmd   (cmd_w),
        .code      (code_w),
        .sample    (sample_w),
        .in_commit (in_commit)
    );

    peci_poll_commit #(.TEMP_W(TEMP_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .in_commit   (in_commit),
        .cfg         (cfg),
        .code        (code_w),
        .sample      (sample_w),
        .temp_q      (temp_q),
        .temp_commit (temp_commit)
    );
endmodule

// File: rtl/peci_poll_seq_chk.sv
module peci_poll_seq_chk #(
    parameter int TEMP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mon_en,
    input logic              man_go,
    input logic              eng_req,
    input logic              eng_ack,
    input logic              temp_commit,
    input logic [TEMP_W-1:0] temp_q,
    input logic [2:0]        state,
    input logic [7:0]        code,
    input logic [5:0]        cfg
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_req |=> !eng_req); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !temp_commit |=> $stable(temp_q)); // R11

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        temp_commit |=> !temp_commit); // R11

    AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        temp_commit |-> $past(eng_ack)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd0 && !mon_en && !man_go) |=> !eng_req); // R3

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        temp_commit |-> !(code == 8'h82 && !cfg[1])); // R6

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        temp_commit |-> !(code[7] && code != 8'h82)); // R9
endmodule

bind peci_poll_seq peci_poll_seq_chk #(.TEMP_W(TEMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mon_en      (mon_en),
    .man_go      (man_go),
    .eng_req     (eng_req),
    .eng_ack     (eng_ack),
    .temp_commit (temp_commit),
    .temp_q      (temp_q),
    .state       (state_bits),
    .code        (code_w),
    .cfg         (cfg_bits)
);

// File: tb/peci_poll_seq_bench.sv
`timescale 1ns/1ps
module peci_poll_seq_bench;
    localparam int TW       = 16;
    localparam int INTERVAL = 16;
    localparam int LIMIT    = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mon_en = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic          man_start = 1'b0;
    logic          man_pending = 1'b0;
    logic          eng_ack = 1'b0;
    logic [7:0]    eng_cc = '0;
    logic [TW-1:0] eng_data = '0;
    logic          eng_req;
    logic [1:0]    eng_cmd;
    logic [TW-1:0] temp_q;
    logic          temp_commit;

    always #2.5 clk = ~clk;

    peci_poll_seq #(.TEMP_W(TW), .POLL_INTERVAL(INTERVAL)) u_peci_poll_seq (
        .clk(clk), .rst(rst), .mon_en(mon_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .man_start(man_start), .man_pending(man_pending), .eng_req(eng_req),
        .eng_cmd(eng_cmd), .eng_ack(eng_ack), .eng_cc(eng_cc), .eng_data(eng_data),
        .temp_q(temp_q), .temp_commit(temp_commit)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int b_cfg = 0, q_cc = 0, t_cc = 0, t_data = 0, lat = 1;
    int busy = 0, cnt = 0, cur_cmd = 0, prev_req = 0, query_seen = 0;
    int commit_next = 0, commit_act = 0, commit_val = 0, upd_pend = 0, upd_val = 0;
    int exp_temp = 0, rounds = 0, n_man = 0, n_req = 0, last_cmd = 0, prior_cmd = 0;
    int tcyc[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // 0 hold, 1 load value, 2 load zero
    function automatic int bexp(input int code);
        if (code == 130) begin
            if ((b_cfg & 2) == 0) return 0;
            if ((b_cfg & 8) != 0) return 2;
            return ((b_cfg & 4) != 0) ? 1 : 0;
        end
        if (code >= 128) return 0;
        if ((b_cfg & 32) != 0) return 2;
        return ((b_cfg & 16) != 0) ? 1 : 0;
    endfunction

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic step;
        int strobe_exp;
        int code;
        @(negedge clk);
        cyc++;
        if (cyc > LIMIT) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, LIMIT);
            finish_run();
        end
        strobe_exp = 0;
        if (upd_pend != 0) begin exp_temp = upd_val; upd_pend = 0; end
        if (commit_next != 0) begin
            commit_next = 0;
            rounds++;
            if (commit_act != 0) begin
                strobe_exp = 1; upd_pend = 1; upd_val = commit_val;
            end
        end
        if (!rst) begin
            chk(int'(temp_q) == exp_temp, "R11 temp_q value", int'(temp_q), exp_temp);
            chk(int'(temp_commit) == strobe_exp, "R11 commit strobe", int'(temp_commit), strobe_exp);
        end
        eng_ack = 1'b0;
        if (busy != 0) begin
            cnt--;
            if (cnt == 0) begin
                busy = 0;
                eng_ack = 1'b1;
                case (cur_cmd)
                    1: begin eng_cc = 8'(q_cc); eng_data = '0; end
                    2: begin eng_cc = 8'(t_cc); eng_data = TW'(t_data); end
                    default: begin eng_cc = 8'h00; eng_data = 16'hBEEF; end
                endcase
                if (cur_cmd == 2) begin
                    code = (query_seen != 0) ? q_cc : t_cc;
                    commit_act = bexp(code);
                    commit_val = (commit_act == 2) ? 0 : t_data;
                    commit_next = 1;
                    query_seen = 0;
                end
            end
        end
        if (eng_req) begin
            n_req++;
            chk(busy == 0 && prev_req == 0, "R5 request spacing", busy + prev_req, 0);
            cur_cmd = int'(eng_cmd);
            prior_cmd = last_cmd;
            last_cmd = cur_cmd;
            busy = 1;
            cnt = lat;
            if (cur_cmd == 1) begin
                chk((b_cfg & 1) == 1, "R4 query only when enabled", b_cfg & 1, 1);
                query_seen = 1;
            end
            if (cur_cmd == 2) begin
                chk(query_seen == (b_cfg & 1), "R4 query precedes read", query_seen, b_cfg & 1);
                tcyc.push_back(cyc);
            end
            if (cur_cmd == 3) n_man++;
        end
        prev_req = int'(eng_req);
    endtask

    task automatic write_cfg(input int v);
        cfg_wdata = 6'(v);
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
        b_cfg = v;
    endtask

    task automatic run_round;
        int r;
        r = rounds;
        mon_en = 1'b1;
        while (rounds == r) step();
        step();
        step();
        mon_en = 1'b0;
        step();
    endtask

    initial begin
        int m0;
        int n0;
        int r0;
        repeat (3) step();
        chk(temp_q == '0, "R2 reset temp_q", int'(temp_q), 0);
        chk(temp_commit == 1'b0, "R2 reset strobe", int'(temp_commit), 0);
        chk(eng_req == 1'b0, "R2 reset request", int'(eng_req), 0);
        rst = 1'b0;
        step();

        // R1: reset policy = all off, no query, nothing committed
        t_cc = 0; t_data = 16'h1111;
        run_round();
        chk(temp_q == 16'h0000, "R1 reset policy holds", int'(temp_q), 0);
        chk(last_cmd == 2, "R1 no query after reset", last_cmd, 2);

        // R8 normal code value commit, no query
        write_cfg(6'h10); t_cc = 0; t_data = 16'h1234; lat = 2;
        run_round();
        chk(temp_q == 16'h1234, "R8 normal value", int'(temp_q), 16'h1234);

        // R10 query code decides even though read code has error bit
        write_cfg(6'h11); q_cc = 0; t_cc = 8'h85; t_data = 16'h2222; lat = 1;
        run_round();
        chk(temp_q == 16'h2222, "R10 query code used", int'(temp_q), 16'h2222);
        chk(prior_cmd == 1 && last_cmd == 2, "R4 query then read", prior_cmd * 16 + last_cmd, 16'h12);

        // R9/R10 no query: read code with error bit holds
        write_cfg(6'h10); t_cc = 8'h85; t_data = 16'h3333;
        run_round();
        chk(temp_q == 16'h2222, "R9 error code holds", int'(temp_q), 16'h2222);

        // R6 special code with gate clear
        write_cfg(6'h05); q_cc = 8'h82; t_cc = 0; t_data = 16'h4444; lat = 3;
        run_round();
        chk(temp_q == 16'h2222, "R6 gate blocks", int'(temp_q), 16'h2222);

        // R7 gate set, value
        write_cfg(6'h07);
        run_round();
        chk(temp_q == 16'h4444, "R7 special value", int'(temp_q), 16'h4444);

        // R7 zero takes priority
        write_cfg(6'h0F); t_data = 16'h4545;
        run_round();
        chk(temp_q == 16'h0000, "R7 special zero", int'(temp_q), 0);

        // R8 normal code with query
        write_cfg(6'h11); q_cc = 8'h01; t_data = 16'h5555; lat = 2;
        run_round();
        chk(temp_q == 16'h5555, "R8 normal value after query", int'(temp_q), 16'h5555);
        write_cfg(6'h31); t_data = 16'h5656;
        run_round();
        chk(temp_q == 16'h0000, "R8 normal zero priority", int'(temp_q), 0);

        // R9 error code with every enable on
        write_cfg(6'h3F); q_cc = 8'h85; t_data = 16'h6666;
        run_round();
        chk(temp_q == 16'h0000, "R9 error code holds all enables", int'(temp_q), 0);

        // R3 quiet while monitoring off
        n0 = n_req;
        repeat (60) step();
        chk(n_req == n0, "R3 no request with monitoring off", n_req - n0, 0);

        // R12 manual start without pending flag
        m0 = n_man;
        man_start = 1'b1; man_pending = 1'b0;
        step();
        man_start = 1'b0;
        repeat (6) step();
        chk(n_man == m0, "R12 ignored without pending", n_man - m0, 0);

        // R12 manual start accepted in idle
        man_start = 1'b1; man_pending = 1'b1;
        step();
        man_start = 1'b0;
        repeat (8) step();
        chk(n_man == m0 + 1 && last_cmd == 3, "R12 manual issued", last_cmd, 3);

        // R12 manual start ignored during a poll
        write_cfg(6'h11); q_cc = 0; t_data = 16'h7777; lat = 3;
        m0 = n_man;
        r0 = rounds;
        mon_en = 1'b1;
        while (query_seen == 0) step();
        man_start = 1'b1;
        step();
        man_start = 1'b0;
        while (rounds == r0) step();
        repeat (2) step();
        mon_en = 1'b0;
        repeat (4) step();
        chk(n_man == m0, "R12 ignored while busy", n_man - m0, 0);
        man_pending = 1'b0;

        // R3 poll spacing
        lat = 2;
        tcyc.delete();
        r0 = rounds;
        mon_en = 1'b1;
        while (rounds < r0 + 4) step();
        mon_en = 1'b0;
        repeat (4) step();
        for (int i = 1; i < tcyc.size(); i++)
            chk(tcyc[i] - tcyc[i-1] == INTERVAL, "R3 poll interval", tcyc[i] - tcyc[i-1], INTERVAL);

        finish_run();
    end
endmodule